// File: doc/BRIEF.md
# Miss Buffer with Leading-Load Cycle Counter

This block tracks outstanding last-level cache misses in a small pool of entries and measures how long the leading miss spends waiting for memory. A miss request claims the lowest-numbered free entry. The block reports the entry index on the allocation port in the same cycle. The entry stays held until a fill response naming that index comes back. Responses may arrive in any order, and several misses may be outstanding at once. When every entry is held, the ready output drops and further requests are not taken.

Two saturating counters run beside the pool. The first counts core cycles in which the halt input is low. The second counts cycles in which entry 0, the highest-priority entry, is occupied. The entry-0 count is an estimate of memory-bound time. Together the two counts are enough to split run time into a part that scales with core frequency and a part that does not. A synchronous clear input zeroes both counters.

Occupancy is summarised by a three-state machine: `POOL_EMPTY`, `POOL_PARTIAL` and `POOL_FULL`. It has these transitions:
- `fill_first`: from `POOL_EMPTY` to `POOL_PARTIAL` on the first claim.
- `drain_last`: from `POOL_PARTIAL` to `POOL_EMPTY` when the last held entry is released.
- `fill_last`: from `POOL_PARTIAL` to `POOL_FULL` when the last free entry is claimed.
- `free_one`: from `POOL_FULL` to `POOL_PARTIAL` on any release.

In every other case the state holds.

Top module: `missbuf_ll`

## Requirements
- R1: After reset all entries are free, `miss_ready` is 1, `miss_idx` is 0 and both counters read 0.
- R2: `miss_idx` always shows the lowest-numbered free entry, because entry 0 has the highest priority. A cycle with `miss_req` and `miss_ready` both high claims that entry at the clock edge.
- R3: A claimed entry stays occupied until a cycle with `fill_vld` high and `fill_idx` equal to its index. It is freed at that edge, and fills may return in any order.
- R4: While all N entries are occupied, `miss_ready` is 0, `miss_idx` is 0, and `miss_req` claims nothing.
- R5: A miss and a fill in the same cycle are handled as follows. Allocation uses the occupancy from before the fill. The freed entry can be claimed from the next cycle on. A full pool receiving a fill does not accept a miss in that cycle.
- R6: A fill that names a free entry is ignored. In particular, it does not cancel a claim of that same entry made in the same cycle.
- R7: `busy_cycles` increments on every clock edge at which `halted` is 0, and it holds while `halted` is 1.
- R8: `lead_cycles` increments on every clock edge at which entry 0 was occupied during the cycle, whether or not `halted` is high.
- R9: Both counters stop at all ones (2^CNT_W-1, default width 48) instead of wrapping.
- R10: When `ctr_clr` is high at an edge, both counters become 0, and the clear wins over any increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_req | input | 1 | New miss wants an entry |
| miss_ready | output | 1 | At least one entry is free |
| miss_idx | output | $clog2(N) | Index the next accepted miss will claim |
| fill_vld | input | 1 | Fill response this cycle |
| fill_idx | input | $clog2(N) | Entry the fill response releases |
| halted | input | 1 | Core is halted this cycle |
| ctr_clr | input | 1 | Synchronous clear of both counters |
| busy_cycles | output | CNT_W | Unhalted-cycle count |
| lead_cycles | output | CNT_W | Entry-0 occupancy count |

## Verification
The bench targets a fill and a miss landing in the same cycle when the pool is full. A design that bypasses the freed entry would accept that miss one cycle early. The bench also sends a fill naming a free entry while that same entry is being claimed; a design that masks without checking occupancy would drop the new claim and later report entry 0 as free. Out-of-order returns check that the lowest free index is chosen again, rather than the oldest or the next in rotation. A shortened counter width drives both counters into saturation, which catches wraparound, and a clear during counting catches an increment that wins over the clear. A halted stretch with entry 0 held shows whether the two counters are wrongly gated by the same condition.

// File: rtl/mb_pkg.sv
`timescale 1ns/1ps
package mb_pkg;
    typedef enum logic [1:0] {
        POOL_EMPTY   = 2'd0,
        POOL_PARTIAL = 2'd1,
        POOL_FULL    = 2'd2
    } pool_state_e;
endpackage

// File: rtl/mb_prio_pick.sv
`timescale 1ns/1ps
module mb_prio_pick #(
    parameter  int N     = 8,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     occupied,
    output logic [IDX_W-1:0] free_idx,
    output logic [N-1:0]     free_oh
);
    // Lowest free index wins: scan downward so the last hit is the lowest.
    always_comb begin
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!occupied[i]) free_idx = IDX_W'(i);
        end
    end

    // One-hot grant: an entry is chosen if it is free and all below are held.
    for (genvar g = 0; g < N; g++) begin : g_oh
        if (g == 0) begin : g_first
            assign free_oh[g] = !occupied[g];
        end else begin : g_rest
            assign free_oh[g] = !occupied[g] && (&occupied[g-1:0]);
        end
    end
endmodule

// File: rtl/mb_sat_ctr.sv
`timescale 1ns/1ps
module mb_sat_ctr #(
    parameter int W = 48
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc && (count != '1)) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/missbuf_ll.sv
`timescale 1ns/1ps
module missbuf_ll
    import mb_pkg::*;
#(
    parameter  int N     = 8,
    parameter  int CNT_W = 48,
    localparam int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             miss_req,
    output logic             miss_ready,
    output logic [IDX_W-1:0] miss_idx,
    input  logic             fill_vld,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic             halted,
    input  logic             ctr_clr,
    output logic [CNT_W-1:0] busy_cycles,
    output logic [CNT_W-1:0] lead_cycles
);
    logic [N-1:0]     valid_q;
    logic [N-1:0]     valid_d;
    logic [N-1:0]     grant_cand;
    logic [N-1:0]     grant_oh;
    logic [N-1:0]     release_oh;
    logic [IDX_W-1:0] free_idx;
    logic             accept;
    logic             occ_none;
    logic             occ_all;
    pool_state_e      state_q;
    pool_state_e      state_d;

    mb_prio_pick #(.N(N)) u_pick (
        .occupied (valid_q),
        .free_idx (free_idx),
        .free_oh  (grant_cand)
    );

    assign accept   = miss_req && miss_ready;
    assign grant_oh = accept ? grant_cand : '0;

    // Only a held entry can be released; a stray fill cannot clear a new claim.
    assign release_oh = fill_vld ? (valid_q & (N'(1) << fill_idx)) : '0;
    assign valid_d    = (valid_q & ~release_oh) | grant_oh;

    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= '0;
        else        valid_q <= valid_d;
    end

    assign occ_none = (valid_d == '0);
    assign occ_all  = &valid_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= POOL_EMPTY;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            POOL_EMPTY: begin
                if (!occ_none) state_d = occ_all ? POOL_FULL : POOL_PARTIAL; // fill_first
            end
            POOL_PARTIAL: begin
                if (occ_none)     state_d = POOL_EMPTY;   // drain_last
                else if (occ_all) state_d = POOL_FULL;    // fill_last
            end
            POOL_FULL: begin
                if (occ_none)      state_d = POOL_EMPTY;
                else if (!occ_all) state_d = POOL_PARTIAL; // free_one
            end
            default: state_d = POOL_EMPTY;
        endcase
    end

    // Outputs
    always_comb begin
        miss_ready = (state_q != POOL_FULL);
        miss_idx   = free_idx;
    end

    mb_sat_ctr #(.W(CNT_W)) u_busy (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ctr_clr),
        .inc   (!halted),
        .count (busy_cycles)
    );

    mb_sat_ctr #(.W(CNT_W)) u_lead (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ctr_clr),
        .inc   (valid_q[0]),
        .count (lead_cycles)
    );
endmodule

// File: rtl/mb_chk.sv
`timescale 1ns/1ps
module mb_chk #(
    parameter  int N     = 8,
    parameter  int CNT_W = 48,
    localparam int IDX_W = $clog2(N)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             miss_req,
    input logic             miss_ready,
    input logic [IDX_W-1:0] miss_idx,
    input logic             fill_vld,
    input logic [IDX_W-1:0] fill_idx,
    input logic             halted,
    input logic             ctr_clr,
    input logic [CNT_W-1:0] busy_cycles,
    input logic [CNT_W-1:0] lead_cycles,
    input logic [N-1:0]     valid_q
);
    assert_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        miss_ready == !(&valid_q));

    assert_idx_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
        miss_ready |-> !valid_q[miss_idx]);

    assert_claim_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_req && miss_ready) |=> valid_q[$past(miss_idx)]);

    assert_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_vld && valid_q[fill_idx]) |=> !valid_q[$past(fill_idx)]);

    for (genvar g = 0; g < N; g++) begin : g_hold
        assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (valid_q[g] && !(fill_vld && fill_idx == IDX_W'(g))) |=> valid_q[g]);
    end

    assert_busy_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !ctr_clr) |=> $stable(busy_cycles));

    assert_lead_inc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q[0] && !ctr_clr && lead_cycles != '1) |=>
            lead_cycles == $past(lead_cycles) + 1'b1);

    assert_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_cycles == '1 && !ctr_clr) |=> busy_cycles == '1);

    assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ctr_clr |=> (busy_cycles == '0 && lead_cycles == '0));
endmodule

bind missbuf_ll mb_chk #(.N(N), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .miss_req    (miss_req),
    .miss_ready  (miss_ready),
    .miss_idx    (miss_idx),
    .fill_vld    (fill_vld),
    .fill_idx    (fill_idx),
    .halted      (halted),
    .ctr_clr     (ctr_clr),
    .busy_cycles (busy_cycles),
    .lead_cycles (lead_cycles),
    .valid_q     (valid_q)
);

// File: tb/sim_missbuf_ll.sv
`timescale 1ns/1ps
module sim_missbuf_ll;
    localparam int N     = 8;
    localparam int CNT_W = 6;
    localparam int IDX_W = $clog2(N);
    localparam logic [CNT_W-1:0] MAXV = '1;

    // {req, fill, fill_idx[2:0], halt, exp_ready, exp_idx[2:0]}
    localparam int NV = 19;
    localparam logic [9:0] VEC [NV] = '{
        {1'b1, 1'b0, 3'd0, 1'b0, 1'b1, 3'd0},
        {1'b1, 1'b0, 3'd0, 1'b0, 1'b1, 3'd1},
        {1'b1, 1'b1, 3'd0, 1'b0, 1'b1, 3'd2},
        {1'b1, 1'b0, 3'd0, 1'b0, 1'b1, 3'd0},
        {1'b0, 1'b1, 3'd1, 1'b1, 1'b1, 3'd3},
        {1'b1, 1'b0, 3'd0, 1'b0, 1'b1, 3'd1},
        {1'b1, 1'b0, 3'd0, 1'b0, 1'b1, 3'd3},
        {1'b1, 1'b0, 3'd0, 1'b0, 1'b1, 3'd4},
        {1'b1, 1'b0, 3'd0, 1'b0, 1'b1, 3'd5},
        {1'b1, 1'b0, 3'd0, 1'b0, 1'b1, 3'd6},
        {1'b1, 1'b0, 3'd0, 1'b0, 1'b1, 3'd7},
        {1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 3'd0},
        {1'b1, 1'b1, 3'd5, 1'b0, 1'b0, 3'd0},
        {1'b1, 1'b0, 3'd0, 1'b0, 1'b1, 3'd5},
        {1'b0, 1'b1, 3'd0, 1'b1, 1'b0, 3'd0},
        {1'b0, 1'b1, 3'd0, 1'b1, 1'b1, 3'd0},
        {1'b1, 1'b1, 3'd0, 1'b0, 1'b1, 3'd0},
        {1'b0, 1'b1, 3'd7, 1'b0, 1'b0, 3'd0},
        {1'b1, 1'b0, 3'd0, 1'b0, 1'b1, 3'd7}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             miss_req = 1'b0;
    logic             miss_ready;
    logic [IDX_W-1:0] miss_idx;
    logic             fill_vld = 1'b0;
    logic [IDX_W-1:0] fill_idx = '0;
    logic             halted = 1'b1;
    logic             ctr_clr = 1'b0;
    logic [CNT_W-1:0] busy_cycles;
    logic [CNT_W-1:0] lead_cycles;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    missbuf_ll #(.N(N), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .miss_req(miss_req), .miss_ready(miss_ready),
        .miss_idx(miss_idx), .fill_vld(fill_vld), .fill_idx(fill_idx),
        .halted(halted), .ctr_clr(ctr_clr),
        .busy_cycles(busy_cycles), .lead_cycles(lead_cycles)
    );

    // Reference occupancy and counters, built from the requirements.
    logic [N-1:0]     m_valid;
    logic [CNT_W-1:0] m_busy;
    logic [CNT_W-1:0] m_lead;

    function automatic int lowest_free(input logic [N-1:0] v);
        for (int i = 0; i < N; i++) if (!v[i]) return i;
        return 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_valid <= '0; m_busy <= '0; m_lead <= '0;
        end else begin
            logic [N-1:0] nv;
            nv = m_valid;
            if (fill_vld && m_valid[fill_idx]) nv[fill_idx] = 1'b0;
            if (miss_req && !(&m_valid)) nv[lowest_free(m_valid)] = 1'b1;
            m_valid <= nv;
            if (ctr_clr) begin
                m_busy <= '0; m_lead <= '0;
            end else begin
                if (!halted && m_busy != MAXV) m_busy <= m_busy + 1'b1;
                if (m_valid[0] && m_lead != MAXV) m_lead <= m_lead + 1'b1;
            end
        end
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive(input logic req, input logic fv, input int fi,
                         input logic hlt, input logic clr);
        miss_req = req; fill_vld = fv; fill_idx = IDX_W'(fi);
        halted = hlt; ctr_clr = clr;
        @(negedge clk);
    endtask

    initial begin
        #4000000;
        fails++;
        $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        longint b0, l0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 ready", miss_ready, 1);
        chk("R1 idx", miss_idx, 0);
        chk("R1 busy", busy_cycles, 0);
        chk("R1 lead", lead_cycles, 0);

        // Vector table: R2 R3 R4 R5 R6 checked on ready/idx, R7 R8 on counters
        for (int k = 0; k < NV; k++) begin
            chk($sformatf("R2/R4 ready step %0d", k), miss_ready, VEC[k][3]);
            if (VEC[k][3]) chk($sformatf("R2 idx step %0d", k), miss_idx, VEC[k][2:0]);
            else           chk($sformatf("R4 idx step %0d", k), miss_idx, 0);
            drive(VEC[k][9], VEC[k][8], int'(VEC[k][7:5]), VEC[k][4], 1'b0);
            chk($sformatf("R7 busy step %0d", k), busy_cycles, m_busy);
            chk($sformatf("R8 lead step %0d", k), lead_cycles, m_lead);
        end
        chk("R5 R6 full after table", miss_ready, 0);

        // R3 release out of order: free 6, then 2; lowest free must be 2
        drive(1'b0, 1'b1, 6, 1'b0, 1'b0);
        drive(1'b0, 1'b1, 2, 1'b0, 1'b0);
        chk("R3 lowest free after out-of-order release", miss_idx, 2);
        for (int i = 0; i < N; i++) drive(1'b0, 1'b1, i, 1'b0, 1'b0);
        chk("R3 all released idx", miss_idx, 0);

        // R8 with halt: hold entry 0, halt for 10 cycles
        drive(1'b1, 1'b0, 0, 1'b0, 1'b1);
        b0 = busy_cycles; l0 = lead_cycles;
        chk("R10 clear", b0, 0);
        for (int i = 0; i < 10; i++) drive(1'b0, 1'b0, 0, 1'b1, 1'b0);
        chk("R7 busy frozen while halted", busy_cycles, b0);
        chk("R8 lead counts while halted", lead_cycles, l0 + 10);

        // R9 saturation of both counters
        for (int i = 0; i < 70; i++) drive(1'b0, 1'b0, 0, 1'b0, 1'b0);
        chk("R9 busy saturates", busy_cycles, MAXV);
        chk("R9 lead saturates", lead_cycles, MAXV);

        // R10 clear wins over increment
        drive(1'b0, 1'b0, 0, 1'b0, 1'b1);
        chk("R10 busy cleared", busy_cycles, 0);
        chk("R10 lead cleared", lead_cycles, 0);
        drive(1'b0, 1'b0, 0, 1'b0, 1'b0);
        chk("R7 busy resumes", busy_cycles, 1);
        chk("R8 lead resumes", lead_cycles, 1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule